// File: doc/BRIEF.md
# Flash Page Protection Region Checker

This block decides whether a flash access may proceed. A controller presents a request made of a bank, a page within that bank and an operation (read, program or erase). The block turns the bank and in-bank page into an absolute page number and compares it against a set of protection region slots. Each slot holds an enable, a base page, a length in pages and three permission fields. The permission fields cover read, program and erase, and each is coded as a redundant 4-bit boolean.

When several enabled slots cover the requested page, the slot with the lowest index supplies the permissions. When no enabled slot covers the page, a separately written default permission set applies. The allow decision, the index of the slot that decided it and a configuration-error flag are all combinational from the request. A registered deny strobe and a registered error strobe follow one cycle after each request-valid cycle, so the controller can abort the operation. A single-cycle write port loads one slot at a time, or loads the default set.

Programming requests are checked against the page addressed by their first word, and erase requests against the page being erased. The controller supplies that page. The block only makes the region-matching, priority and permission decisions.

Top module: `mp_region_check`

## Requirements
- R1: There are 8 region slots, numbered 0 to 7. An enabled slot with base B and size S covers absolute pages B through B+S-1. A slot with S=0 covers no page.
- R2: The absolute page is bank*256 + in-bank page. Bank 1 page 12 is absolute page 268, and bank 0 page 12 is absolute page 12.
- R3: req_op encodes 2'b00 read, 2'b01 program, 2'b10 erase and 2'b11 reserved. Each operation consults only its own field. A reserved op is always denied and never flags an error.
- R4: When enabled slots overlap, the slot with the lowest index decides. The order in which slots were written does not change the outcome.
- R5: A slot takes part in matching only while its enable bit is set. Clearing the enable hands the page to the next covering slot, or to the default.
- R6: Permission fields use 4'b0110 for true and 4'b1001 for false. Any other code denies the access and raises cfg_err for that request.
- R7: A page that no enabled slot covers uses the default read, program and erase fields. In that case hit_valid is 0.
- R8: One cycle after a cycle with req_valid high, deny_q equals the inverse of that cycle's allow and err_q equals that cycle's cfg_err. Both are 0 one cycle after a cycle with req_valid low.
- R9: After reset, all slots are disabled with size 0 and false fields. The default fields are false, so every access is denied and deny_q and err_q are 0.
- R10: hit_valid reports that some enabled slot covers the page, and hit_idx gives the index of the deciding slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one region slot |
| cfg_idx | input | 3 | Slot index to write |
| cfg_en | input | 1 | Slot enable value |
| cfg_base | input | 9 | Slot base absolute page |
| cfg_size | input | 10 | Slot size in pages |
| cfg_rd | input | 4 | Slot read permission |
| cfg_prog | input | 4 | Slot program permission |
| cfg_erase | input | 4 | Slot erase permission |
| dflt_we | input | 1 | Write the default permission set |
| dflt_rd | input | 4 | Default read permission |
| dflt_prog | input | 4 | Default program permission |
| dflt_erase | input | 4 | Default erase permission |
| req_valid | input | 1 | Request strobe |
| req_bank | input | 1 | Bank of the requested page |
| req_page | input | 8 | Page within the bank |
| req_op | input | 2 | Operation code |
| allow | output | 1 | Combinational grant |
| cfg_err | output | 1 | Selected field holds an illegal code |
| hit_valid | output | 1 | Some enabled slot covers the page |
| hit_idx | output | 3 | Deciding slot index |
| deny_q | output | 1 | Registered deny strobe |
| err_q | output | 1 | Registered config-error strobe |

## Verification
On every cycle the assertions check several properties. The deciding slot must really match the page, and no lower slot may match it. With no hit there must be no match. An illegal field code or a reserved op can never grant access. The registered strobes must track the previous cycle's request. None of these properties can tell whether the absolute page arithmetic, the coverage bounds or the field chosen for each operation are right. The bench model settles those by replaying the overlapping three-slot layout written in two orders, plus slot disabling, bank addressing, zero-size slots and corrupted field codes.

// File: rtl/mp_pkg.sv
package mp_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } mp_op_e;

  localparam logic [3:0] MB_TRUE  = 4'b0110;
  localparam logic [3:0] MB_FALSE = 4'b1001;

  typedef struct packed {
    logic [3:0] rd;
    logic [3:0] prog;
    logic [3:0] erase;
  } mp_perm_t;

  localparam mp_perm_t PERM_NONE = '{rd: MB_FALSE, prog: MB_FALSE, erase: MB_FALSE};

  function automatic logic mb_is_true(input logic [3:0] v);
    return v == MB_TRUE;
  endfunction

  function automatic logic mb_is_legal(input logic [3:0] v);
    return (v == MB_TRUE) || (v == MB_FALSE);
  endfunction

  function automatic logic [3:0] perm_field(input mp_perm_t p, input mp_op_e op);
    case (op)
      OP_READ:  return p.rd;
      OP_PROG:  return p.prog;
      OP_ERASE: return p.erase;
      default:  return MB_FALSE;
    endcase
  endfunction

endpackage

// File: rtl/mp_region_regs.sv
module mp_region_regs
  import mp_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int PAGE_W      = 9,
  parameter int SIZE_W      = 10,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic                   cfg_en,
  input  logic [PAGE_W-1:0]      cfg_base,
  input  logic [SIZE_W-1:0]      cfg_size,
  input  mp_perm_t               cfg_perm,
  input  logic                   dflt_we,
  input  mp_perm_t               dflt_perm,
  output logic [NUM_REGIONS-1:0] slot_en,
  output logic [PAGE_W-1:0]      slot_base [NUM_REGIONS],
  output logic [SIZE_W-1:0]      slot_size [NUM_REGIONS],
  output mp_perm_t               slot_perm [NUM_REGIONS],
  output mp_perm_t               dflt_perm_q
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    logic wr_this;
    assign wr_this = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_en[g]   <= 1'b0;
        slot_base[g] <= '0;
        slot_size[g] <= '0;
        slot_perm[g] <= PERM_NONE;
      end else if (wr_this) begin
        slot_en[g]   <= cfg_en;
        slot_base[g] <= cfg_base;
        slot_size[g] <= cfg_size;
        slot_perm[g] <= cfg_perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_perm_q <= PERM_NONE;
    end else if (dflt_we) begin
      dflt_perm_q <= dflt_perm;
    end
  end

endmodule

// File: rtl/mp_region_match.sv
module mp_region_match #(
  parameter int NUM_REGIONS = 8,
  parameter int PAGE_W      = 9,
  parameter int SIZE_W      = 10
) (
  input  logic [PAGE_W-1:0]      page,
  input  logic [NUM_REGIONS-1:0] slot_en,
  input  logic [PAGE_W-1:0]      slot_base [NUM_REGIONS],
  input  logic [SIZE_W-1:0]      slot_size [NUM_REGIONS],
  output logic [NUM_REGIONS-1:0] match_vec
);

  localparam int CW = SIZE_W + 1;

  function automatic logic covers(input logic [PAGE_W-1:0] pg,
                                  input logic [PAGE_W-1:0] base,
                                  input logic [SIZE_W-1:0] size);
    logic [CW-1:0] p_ext, lo, hi;
    p_ext = CW'(pg);
    lo    = CW'(base);
    hi    = lo + CW'(size);
    return (p_ext >= lo) && (p_ext < hi);
  endfunction

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign match_vec[g] = slot_en[g] && covers(page, slot_base[g], slot_size[g]);
  end

endmodule

// File: rtl/mp_prio_pick.sv
module mp_prio_pick #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_REGIONS-1:0] match_vec,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_sel
);

  always_comb begin
    hit     = 1'b0;
    hit_sel = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_sel = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mp_region_check.sv
module mp_region_check
  import mp_pkg::*;
#(
  parameter int NUM_REGIONS    = 8,
  parameter int BANKS          = 2,
  parameter int PAGES_PER_BANK = 256,
  localparam int IDX_W    = $clog2(NUM_REGIONS),
  localparam int BANK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int INPAGE_W = $clog2(PAGES_PER_BANK),
  localparam int PAGE_W   = $clog2(BANKS * PAGES_PER_BANK),
  localparam int SIZE_W   = PAGE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_en,
  input  logic [PAGE_W-1:0]   cfg_base,
  input  logic [SIZE_W-1:0]   cfg_size,
  input  logic [3:0]          cfg_rd,
  input  logic [3:0]          cfg_prog,
  input  logic [3:0]          cfg_erase,
  input  logic                dflt_we,
  input  logic [3:0]          dflt_rd,
  input  logic [3:0]          dflt_prog,
  input  logic [3:0]          dflt_erase,
  input  logic                req_valid,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [INPAGE_W-1:0] req_page,
  input  logic [1:0]          req_op,
  output logic                allow,
  output logic                cfg_err,
  output logic                hit_valid,
  output logic [IDX_W-1:0]    hit_idx,
  output logic                deny_q,
  output logic                err_q
);

  function automatic logic [PAGE_W-1:0] abs_page(input logic [BANK_W-1:0] bank,
                                                 input logic [INPAGE_W-1:0] pg);
    return PAGE_W'(bank) * PAGE_W'(PAGES_PER_BANK) + PAGE_W'(pg);
  endfunction

  logic [NUM_REGIONS-1:0] slot_en;
  logic [PAGE_W-1:0]      slot_base [NUM_REGIONS];
  logic [SIZE_W-1:0]      slot_size [NUM_REGIONS];
  mp_perm_t               slot_perm [NUM_REGIONS];
  mp_perm_t               dflt_perm_q;
  logic [NUM_REGIONS-1:0] match_vec;
  logic [PAGE_W-1:0]      page_abs;
  mp_perm_t               chosen_perm;
  logic [3:0]             chosen_field;
  logic                   op_rsvd;

  mp_region_regs #(
    .NUM_REGIONS(NUM_REGIONS),
    .PAGE_W     (PAGE_W),
    .SIZE_W     (SIZE_W),
    .IDX_W      (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_en     (cfg_en),
    .cfg_base   (cfg_base),
    .cfg_size   (cfg_size),
    .cfg_perm   ('{rd: cfg_rd, prog: cfg_prog, erase: cfg_erase}),
    .dflt_we    (dflt_we),
    .dflt_perm  ('{rd: dflt_rd, prog: dflt_prog, erase: dflt_erase}),
    .slot_en    (slot_en),
    .slot_base  (slot_base),
    .slot_size  (slot_size),
    .slot_perm  (slot_perm),
    .dflt_perm_q(dflt_perm_q)
  );

  assign page_abs = abs_page(req_bank, req_page);

  mp_region_match #(
    .NUM_REGIONS(NUM_REGIONS),
    .PAGE_W     (PAGE_W),
    .SIZE_W     (SIZE_W)
  ) u_match (
    .page     (page_abs),
    .slot_en  (slot_en),
    .slot_base(slot_base),
    .slot_size(slot_size),
    .match_vec(match_vec)
  );

  mp_prio_pick #(
    .NUM_REGIONS(NUM_REGIONS),
    .IDX_W      (IDX_W)
  ) u_pick (
    .match_vec(match_vec),
    .hit      (hit_valid),
    .hit_sel  (hit_idx)
  );

  assign chosen_perm  = hit_valid ? slot_perm[hit_idx] : dflt_perm_q;
  assign op_rsvd      = (mp_op_e'(req_op) == OP_RSVD);
  assign chosen_field = perm_field(chosen_perm, mp_op_e'(req_op));
  assign allow        = !op_rsvd && mb_is_true(chosen_field);
  assign cfg_err      = !op_rsvd && !mb_is_legal(chosen_field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      deny_q <= req_valid && !allow;
      err_q  <= req_valid && cfg_err;
    end
  end

endmodule

// File: rtl/mp_region_check_sva.sv
module mp_region_check_sva #(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [1:0]             req_op,
  input logic                   allow,
  input logic                   cfg_err,
  input logic                   hit_valid,
  input logic [IDX_W-1:0]       hit_idx,
  input logic                   deny_q,
  input logic                   err_q,
  input logic [NUM_REGIONS-1:0] match_vec
);

  logic [NUM_REGIONS-1:0] below_mask;
  always_comb below_mask = (NUM_REGIONS'(1) << hit_idx) - NUM_REGIONS'(1);

  assert_deny_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (deny_q == !$past(allow)));

  assert_err_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (err_q == $past(cfg_err)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!deny_q && !err_q));

  assert_bad_code_denies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !allow);

  assert_rsvd_op_denies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_op == 2'b11) |-> (!allow && !cfg_err));

  assert_hit_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> match_vec[hit_idx]);

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> ((match_vec & below_mask) == '0));

  assert_miss_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (match_vec == '0));

endmodule

bind mp_region_check mp_region_check_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_op   (req_op),
  .allow    (allow),
  .cfg_err  (cfg_err),
  .hit_valid(hit_valid),
  .hit_idx  (hit_idx),
  .deny_q   (deny_q),
  .err_q    (err_q),
  .match_vec(match_vec)
);

// File: tb/mp_region_check_bench.sv
`timescale 1ns/1ps
module mp_region_check_bench;

  localparam logic [3:0] T = 4'b0110;
  localparam logic [3:0] F = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_we = 0, cfg_en = 0, dflt_we = 0, req_valid = 0, req_bank = 0;
  logic [2:0] cfg_idx = 0;
  logic [8:0] cfg_base = 0;
  logic [9:0] cfg_size = 0;
  logic [3:0] cfg_rd = F, cfg_prog = F, cfg_erase = F;
  logic [3:0] dflt_rd = F, dflt_prog = F, dflt_erase = F;
  logic [7:0] req_page = 0;
  logic [1:0] req_op = 0;
  logic       allow, cfg_err, hit_valid, deny_q, err_q;
  logic [2:0] hit_idx;

  mp_region_check u_mp_region_check (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_rd(cfg_rd), .cfg_prog(cfg_prog),
    .cfg_erase(cfg_erase), .dflt_we(dflt_we), .dflt_rd(dflt_rd), .dflt_prog(dflt_prog),
    .dflt_erase(dflt_erase), .req_valid(req_valid), .req_bank(req_bank),
    .req_page(req_page), .req_op(req_op), .allow(allow), .cfg_err(cfg_err),
    .hit_valid(hit_valid), .hit_idx(hit_idx), .deny_q(deny_q), .err_q(err_q)
  );

  // Behavioural model state
  bit         m_en   [8];
  int         m_base [8];
  int         m_size [8];
  logic [3:0] m_perm [8][3];
  logic [3:0] m_dflt [3];
  bit         e_deny, e_err;
  int         checks = 0, fails = 0;
  string      cur_tag = "R9";

  task automatic model(output bit al, output bit er, output bit hv, output int hi);
    int page;
    logic [3:0] f;
    page = int'(req_bank) * 256 + int'(req_page);
    hv = 0; hi = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_en[i] && page >= m_base[i] && page < m_base[i] + m_size[i]) begin
        hv = 1; hi = i; break;
      end
    end
    if (req_op == 2'b11) begin
      al = 0; er = 0;
    end else begin
      f  = hv ? m_perm[hi][req_op] : m_dflt[req_op];
      al = (f == T);
      er = !(f == T || f == F);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_base[i] = 0; m_size[i] = 0;
      for (int k = 0; k < 3; k++) m_perm[i][k] = F;
    end
    for (int k = 0; k < 3; k++) m_dflt[k] = F;
    e_deny = 0; e_err = 0;
  endtask

  always @(posedge clk) begin
    bit al, er, hv;
    int hi;
    if (!rst_n) begin
      model_reset();
    end else begin
      model(al, er, hv, hi);
      e_deny = req_valid && !al;
      e_err  = req_valid && er;
      if (cfg_we) begin
        m_en[cfg_idx] = cfg_en; m_base[cfg_idx] = int'(cfg_base);
        m_size[cfg_idx] = int'(cfg_size);
        m_perm[cfg_idx][0] = cfg_rd; m_perm[cfg_idx][1] = cfg_prog;
        m_perm[cfg_idx][2] = cfg_erase;
      end
      if (dflt_we) begin
        m_dflt[0] = dflt_rd; m_dflt[1] = dflt_prog; m_dflt[2] = dflt_erase;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (bank %0d page %0d op %0d)",
               tag, what, act, exp, req_bank, req_page, req_op);
    end
  endtask

  always @(negedge clk) begin
    bit al, er, hv;
    int hi;
    if (rst_n) begin
      model(al, er, hv, hi);
      chk(cur_tag, "allow", allow, al);
      chk("R6", "cfg_err", cfg_err, er);
      chk("R10", "hit_valid", hit_valid, hv);
      if (hv) chk("R10", "hit_idx", hit_idx, hi);
      chk("R8", "deny_q", deny_q, e_deny);
      chk("R8", "err_q", err_q, e_err);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_slot(int idx, bit en, int base, int size,
                         logic [3:0] r, logic [3:0] p, logic [3:0] e);
    tick();
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_base = 9'(base);
    cfg_size = 10'(size); cfg_rd = r; cfg_prog = p; cfg_erase = e;
    tick();
    cfg_we = 0;
  endtask

  task automatic wr_dflt(logic [3:0] r, logic [3:0] p, logic [3:0] e);
    tick();
    dflt_we = 1; dflt_rd = r; dflt_prog = p; dflt_erase = e;
    tick();
    dflt_we = 0;
  endtask

  task automatic access(int bank, int pg, int op);
    tick();
    req_valid = 1; req_bank = bank[0]; req_page = 8'(pg); req_op = 2'(op);
    tick();
    req_valid = 0;
  endtask

  task automatic sweep_bank1(int lo, int hi);
    for (int pg = lo; pg <= hi; pg++)
      for (int op = 0; op < 4; op++) access(1, pg, op);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9: reset state, every access denied, strobes quiet
    cur_tag = "R9";
    #1;
    checks++;
    if (allow !== 1'b0 || deny_q !== 1'b0 || err_q !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset outputs actual=%b%b%b expected=000", allow, deny_q, err_q);
    end
    access(0, 0, 0);
    access(1, 200, 2);

    // R7: default region governs uncovered pages
    cur_tag = "R7";
    wr_dflt(T, T, T);
    access(0, 5, 0); access(0, 5, 1); access(0, 5, 2);
    wr_dflt(T, F, T);
    access(0, 5, 1); access(1, 5, 0);

    // R4: overlapping slots written from the highest index down
    cur_tag = "R4";
    wr_slot(7, 1, 266, 6, T, T, T);
    sweep_bank1(8, 17);
    wr_slot(3, 1, 267, 4, F, T, T);
    sweep_bank1(8, 17);
    wr_slot(0, 1, 268, 2, T, F, T);
    sweep_bank1(8, 17);

    // R3: per-operation fields and reserved op on a slot-0 page
    cur_tag = "R3";
    access(1, 12, 0); access(1, 12, 1); access(1, 12, 2); access(1, 12, 3);

    // R2: same in-bank page, different banks
    cur_tag = "R2";
    access(0, 12, 1); access(1, 12, 1); access(0, 11, 0); access(1, 11, 0);

    // R5: disabling the middle slot hands its pages to slot 7
    cur_tag = "R5";
    wr_slot(3, 0, 267, 4, F, T, T);
    sweep_bank1(10, 15);

    // R4: same layout written in ascending order gives identical decisions
    cur_tag = "R4";
    wr_slot(0, 0, 0, 0, F, F, F);
    wr_slot(7, 0, 0, 0, F, F, F);
    wr_slot(0, 1, 268, 2, T, F, T);
    wr_slot(3, 1, 267, 4, F, T, T);
    wr_slot(7, 1, 266, 6, T, T, T);
    sweep_bank1(9, 16);

    // R1: boundary pages and zero-size slot
    cur_tag = "R1";
    wr_dflt(F, F, F);
    wr_slot(5, 1, 100, 0, T, T, T);
    access(0, 100, 0); access(0, 99, 0);
    wr_slot(5, 1, 100, 3, T, T, T);
    access(0, 99, 0); access(0, 100, 0); access(0, 102, 0); access(0, 103, 0);
    wr_slot(6, 1, 511, 1, T, T, T);
    access(1, 255, 2); access(1, 254, 2);

    // R6: corrupted codes deny and flag, legal neighbours unaffected
    cur_tag = "R6";
    wr_slot(0, 1, 268, 2, 4'b0111, F, 4'b0000);
    access(1, 12, 0); access(1, 12, 1); access(1, 12, 2); access(1, 13, 3);
    wr_dflt(4'b1111, T, F);
    access(0, 50, 0); access(0, 50, 1); access(0, 50, 2);

    // R8: back-to-back requests without idle gaps
    cur_tag = "R8";
    tick();
    req_valid = 1; req_bank = 1; req_page = 12; req_op = 0;
    tick(); req_op = 1;
    tick(); req_page = 10; req_op = 0;
    tick(); req_bank = 0; req_page = 100;
    tick(); req_valid = 0;
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule